// File: doc/BRIEF.md
# Page-Buffered Non-Volatile Write Sequencer

This block sits behind a serial-bus slave front end and turns a stream of decoded write events into page commits on a byte-wide non-volatile array. The front end reports a bus START, the start address of a write, each received data byte and the closing STOP as single-cycle pulses. Data bytes are gathered into a one-page staging buffer. The array is touched only when the STOP arrives and at least one general-purpose byte was gathered. A self-timed write cycle then begins. It is modelled as a fixed number of system clocks, and a busy flag stays high for all of it.

A page is 16 bytes. All bytes of a page share the upper address bits and differ only in the low four column bits. During the write cycle the sequencer issues one array write request for each gathered byte, and only for those bytes, so the rest of the page keeps its contents. The two highest addresses hold volatile state that another block owns, and the two addresses below them are reserved. Bytes sent to any of these four addresses are accepted on the bus but never reach the array. Reads of the array pass straight through with one cycle of latency.

Top module: `pgwr_top`

## Requirements
- R1: After reset, busy is low, no array write request is issued, and every array byte reads back as 00h.
- R2: The address given with a write selects a page (upper address bits) and a starting column (bits 3..0). Each following data byte goes to the next column of that same page.
- R3: A STOP that ends a write holding at least one general-purpose byte raises busy in the cycle after the STOP. Busy then stays high for exactly CYCLE_CLKS cycles. Busy never rises at any other time.
- R4: A write that only touched the two top (volatile) addresses ends at STOP with no busy and no array write.
- R5: The two reserved addresses, the top address minus 3 and minus 2, are never written in the array.
- R6: The column counter wraps from 15 to 0 inside the page. A later byte sent to the same column replaces the earlier one.
- R7: A START that arrives before the STOP discards all gathered bytes, and a STOP after it starts no write cycle.
- R8: During a commit only the gathered columns are written, one request each, and every other byte of the page keeps its value.
- R9: While busy is high, START, STOP, address, data and read events have no effect, and the read data output holds its value.
- R10: A read request while idle returns the addressed array byte on the read data output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startEv | input | 1 | One-cycle pulse: bus START seen |
| stopEv | input | 1 | One-cycle pulse: bus STOP seen |
| addrValid | input | 1 | One-cycle pulse: write start address on addrIn |
| addrIn | input | ADDR_W | Write start address |
| dataValid | input | 1 | One-cycle pulse: data byte on dataIn |
| dataIn | input | DATA_W | Received data byte |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, valid the cycle after rdEn |
| arrWrEn | output | 1 | Array write request |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The assertions assume that the front end raises at most one of START, STOP, address-valid and data-valid in any cycle, and they check this assumption at the top. The bench drives each event as its own one-cycle pulse on a falling edge, so the rule always holds, including the deliberate event bursts sent while busy. The commit-window and reserved-address properties also assume that CYCLE_CLKS is at least the page size. The bench builds a 128-byte configuration with a 20-cycle write time to keep that true.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  // Strobes from the sequencing control into the page datapath.
  typedef struct packed {
    logic clearBuf;   // drop every gathered byte
    logic loadAddr;   // capture page and starting column
    logic storeByte;  // place a data byte at the current column
    logic scanEn;     // commit scan is presenting a column
  } seqStrobes_t;
endpackage

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int CYCLE_CLKS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              addrValid,
  input  logic              dataValid,
  input  logic              anyMarked,
  output seqStrobes_t       strb,
  output logic [PAGE_W-1:0] scanIdx,
  output logic              busy
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);

  typedef enum logic {ST_IDLE, ST_BUSY} seqState_t;

  seqState_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (stopEv && anyMarked) begin
          state <= ST_BUSY;
          cnt   <= '0;
        end
        ST_BUSY: if (cnt == LAST_CNT) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb    = '0;
    scanIdx = cnt[PAGE_W-1:0];
    if (state == ST_IDLE) begin
      strb.clearBuf  = startEv;
      strb.loadAddr  = addrValid;
      strb.storeByte = dataValid;
    end else begin
      strb.scanEn   = (cnt < CNT_W'(PAGE_BYTES));
      strb.clearBuf = (cnt == LAST_CNT);
    end
  end

  assign busy = (state == ST_BUSY);

  // Independent run-length counter for the busy window check.
  logic [CNT_W:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  assert_commit_on_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEv));
  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == (CNT_W+1)'(CYCLE_CLKS));
  assert_idle_stop_commits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopEv && anyMarked) |=> busy);
  assert_no_fill_while_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.storeByte || strb.loadAddr));
endmodule

// File: rtl/pgwr_datapath.sv
module pgwr_datapath
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [PAGE_W-1:0] scanIdx,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              anyMarked,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  // First address that is not general-purpose: top four are reserved/volatile.
  localparam logic [ADDR_W-1:0] GP_LIMIT = {ADDR_W{1'b1}} - ADDR_W'(3);

  logic [PG_W-1:0]       pageReg;
  logic [PAGE_W-1:0]     colReg;
  logic [PAGE_BYTES-1:0] markVec;
  logic [DATA_W-1:0]     slotData [PAGE_BYTES];
  logic [ADDR_W-1:0]     curAddr;
  logic                  isGp;

  assign curAddr = {pageReg, colReg};
  assign isGp    = (curAddr < GP_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      colReg  <= '0;
    end else if (strb.loadAddr) begin
      pageReg <= addrIn[ADDR_W-1:PAGE_W];
      colReg  <= addrIn[PAGE_W-1:0];
    end else if (strb.storeByte) begin
      colReg <= colReg + 1'b1;  // wraps within the page
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData[s] <= '0;
        markVec[s]  <= 1'b0;
      end else if (strb.clearBuf) begin
        markVec[s] <= 1'b0;
      end else if (strb.storeByte && isGp && colReg == PAGE_W'(s)) begin
        slotData[s] <= dataIn;
        markVec[s]  <= 1'b1;
      end
    end
  end

  assign anyMarked = |markVec;
  assign wrEn      = strb.scanEn && markVec[scanIdx];
  assign wrAddr    = {pageReg, scanIdx};
  assign wrData    = slotData[scanIdx];

  assert_no_reserved_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAddr < GP_LIMIT);
  assert_page_held_in_scan_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.scanEn |=> $stable(pageReg));
  assert_marks_gone_after_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearBuf |=> !anyMarked);
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdAccept,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (rdAccept) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/pgwr_top.sv
module pgwr_top
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 4,
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData,
  output logic              busy
);
  seqStrobes_t       strb;
  logic [PAGE_W-1:0] scanIdx;
  logic              anyMarked;

  pgwr_ctrl #(.PAGE_W(PAGE_W), .CYCLE_CLKS(CYCLE_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .addrValid(addrValid), .dataValid(dataValid), .anyMarked(anyMarked),
    .strb(strb), .scanIdx(scanIdx), .busy(busy));

  pgwr_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .scanIdx(scanIdx),
    .addrIn(addrIn), .dataIn(dataIn), .anyMarked(anyMarked),
    .wrEn(arrWrEn), .wrAddr(arrWrAddr), .wrData(arrWrData));

  pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uArr (
    .clk(clk), .rstN(rstN), .wrEn(arrWrEn), .wrAddr(arrWrAddr),
    .wrData(arrWrData), .rdAccept(rdEn && !busy), .rdAddr(rdAddr),
    .rdData(rdData));

  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startEv, stopEv, addrValid, dataValid}));
  assert_write_only_when_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);
  assert_read_held_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(rdData));
endmodule

// File: tb/tb_pgwr_top.sv
module tb_pgwr_top;
  localparam int AW    = 7;
  localparam int DW    = 8;
  localparam int CYC   = 20;
  localparam int DEPTH = 1 << AW;
  localparam int GPLIM = DEPTH - 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startEv = 0, stopEv = 0, addrValid = 0, dataValid = 0, rdEn = 0;
  logic [AW-1:0] addrIn = '0, rdAddr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] rdData, arrWrData;
  logic [AW-1:0] arrWrAddr;
  logic arrWrEn, busy;

  int errors = 0, checks = 0, wrCount = 0;
  logic [DW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  pgwr_top #(.ADDR_W(AW), .PAGE_W(4), .DATA_W(DW), .CYCLE_CLKS(CYC)) dut (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .addrValid(addrValid), .addrIn(addrIn), .dataValid(dataValid), .dataIn(dataIn),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData), .busy(busy));

  always @(negedge clk) if (rstN && arrWrEn) wrCount++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pStart();   startEv = 1; @(negedge clk); startEv = 0; endtask
  task automatic pStop();    stopEv = 1;  @(negedge clk); stopEv = 0;  endtask
  task automatic pAddr(input int a);
    addrValid = 1; addrIn = AW'(a); @(negedge clk); addrValid = 0;
  endtask
  task automatic pData(input int d);
    dataValid = 1; dataIn = DW'(d); @(negedge clk); dataValid = 0;
  endtask
  task automatic rd(input int a, output int v);
    rdEn = 1; rdAddr = AW'(a); @(negedge clk); rdEn = 0; v = int'(rdData);
  endtask

  // Sends a full write; returns how many columns the model expects to commit.
  task automatic sendWrite(input int sa, input int n, input int seed, output int marks);
    logic [DW-1:0] tmp [16];
    bit mk [16];
    int pg;
    for (int c = 0; c < 16; c++) mk[c] = 0;
    pg = sa & ~15;
    pStart(); pAddr(sa);
    for (int i = 0; i < n; i++) begin
      int col, d;
      col = (sa + i) & 15;
      d = (seed * 37 + i * 11 + 1) & 255;
      pData(d);
      if ((pg | col) < GPLIM) begin tmp[col] = DW'(d); mk[col] = 1; end
    end
    marks = 0;
    for (int c = 0; c < 16; c++) if (mk[c]) begin model[pg | c] = tmp[c]; marks++; end
    wrCount = 0;
    pStop();
  endtask

  // Called right after the STOP pulse; measures the busy window.
  task automatic waitCommit(input int marks, input string req);
    int n = 0;
    chk(busy == (marks > 0), "R3 busy after STOP", int'(busy), int'(marks > 0));
    while (busy && n < 4 * CYC) begin n++; @(negedge clk); end
    if (marks > 0) chk(n == CYC, "R3 busy length", n, CYC);
    chk(wrCount == marks, req, wrCount, marks);
  endtask

  task automatic checkAll(input string req);
    int v;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      chk(v == int'(model[a]), req, v, int'(model[a]));
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int m, v, held;
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    chk(busy == 0, "R1 busy after reset", int'(busy), 0);
    chk(arrWrEn == 0, "R1 no write after reset", int'(arrWrEn), 0);
    checkAll("R1 array cleared");

    // R2 R6 R8 R5: sweep every page with varied start column and length
    for (int p = 0; p < DEPTH / 16; p++) begin
      sendWrite(p * 16 + (p * 7) % 16, 1 + (p * 5) % 18, p, m);
      waitCommit(m, "R8 write requests per marked byte");
    end
    checkAll("R2 R6 R5 sweep contents");

    // R8: single byte at the top column of a page; rest of page kept
    sendWrite(2 * 16 + 15, 1, 91, m);
    waitCommit(m, "R8 single top-column write");
    checkAll("R8 neighbours kept");

    // R6: seventeen bytes from column 0, column 0 holds the last byte
    sendWrite(3 * 16, 17, 55, m);
    waitCommit(m, "R6 wrap write count");
    rd(3 * 16, v);
    chk(v == ((55 * 37 + 16 * 11 + 1) & 255), "R6 column 0 overwritten", v,
        (55 * 37 + 16 * 11 + 1) & 255);

    // R4: volatile-only write
    sendWrite(DEPTH - 2, 2, 7, m);
    chk(m == 0, "R4 model marks", m, 0);
    waitCommit(0, "R4 no array write");
    repeat (3) @(negedge clk);
    chk(busy == 0, "R4 stays idle", int'(busy), 0);

    // R7: START before STOP aborts
    pStart(); pAddr(5 * 16); pData(8'hA5); pData(8'h5A); pStart(); wrCount = 0; pStop();
    chk(busy == 0, "R7 no commit after abort", int'(busy), 0);
    repeat (CYC) @(negedge clk);
    chk(wrCount == 0, "R7 no write after abort", wrCount, 0);
    checkAll("R7 array unchanged");

    // R9: events during busy are ignored
    rd(1, held);
    sendWrite(1 * 16 + 4, 3, 200, m);
    chk(busy == 1, "R9 busy entered", int'(busy), 1);
    pStart(); pAddr(6 * 16); pData(8'hEE); pData(8'hEF); pStop();
    rdEn = 1; rdAddr = AW'(16 + 4); @(negedge clk); rdEn = 0;
    chk(int'(rdData) == held, "R9 read ignored while busy", int'(rdData), held);
    while (busy) @(negedge clk);
    chk(wrCount == m, "R9 only original writes", wrCount, m);
    repeat (2) @(negedge clk);
    chk(busy == 0, "R9 no second commit", int'(busy), 0);
    checkAll("R9 R10 array after ignored events");

    // R10: read latency of one cycle
    rd(16 + 5, v);
    chk(v == int'(model[16 + 5]), "R10 read data", v, int'(model[16 + 5]));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule